// File: doc/BRIEF.md
# Tagged Slice Reassembler

This block rebuilds one wide packet from a stream of narrow slices. Each slice arrives on a valid/stall input together with a sequence address and a two-bit opcode. When a slice is accepted, its payload is written into the lane of a wide holding register that its address selects, and a per-lane presence bit is set. When the slice carrying the highest address has been written, the wide packet is presented on a valid/stall output. The consumer takes it on a cycle in which it does not assert stall. That cycle clears the holding register and the presence mask.

A two-state controller runs the process. In `ST_RECV` (data-ready) the block accepts slices. If the accepted slice's opcode has its high bit set and its low bit clear (the jump condition), the transition `RECV->JUMP` is taken. That slice is still written, and the partial packet is presented at once, marked by `out_jump`. In `ST_JUMP` no slices are taken, and the transition `JUMP->RECV` fires on the first cycle in which the output is not stalled. Every other opcode value leaves the machine in `ST_RECV` (the `RECV->RECV` self loop), and `ST_JUMP` holds while the output is stalled (the `JUMP->JUMP` self loop). The update-enable output `upd_en` is high only in `ST_RECV` and only while a slice is accepted or the output packet is consumed. Downstream logic can use it as a single strobe for any register update.

Top module: `slice_reassembler`

## Requirements
- R1: After a synchronous reset the machine is in `ST_RECV`, and `out_valid`, `out_jump`, `out_mask` and `out_data` are all zero.
- R2: A slice is accepted when `in_valid` is high and `in_stall` is low at a clock edge. From the next cycle its payload appears in `out_data` bits `[addr*SLICE_W +: SLICE_W]` and `out_mask[addr]` is set. A repeated address overwrites its lane.
- R3: Accepting a slice whose address is `NUM_SLICES-1` with a non-jump opcode raises `out_valid` on the next cycle, and `out_jump` stays low.
- R4: Accepting a slice with `in_op[1]=1` and `in_op[0]=0` writes the slice, moves the machine to `ST_JUMP`, and raises both `out_valid` and `out_jump` on the next cycle. The opcodes 00, 01 and 11 never cause this transition.
- R5: In `ST_JUMP`, a cycle with `out_stall` low returns the machine to `ST_RECV` on the next cycle. Otherwise the machine stays in `ST_JUMP`.
- R6: `in_stall` is high exactly while `out_valid` is high. While `out_valid` and `out_stall` are both high, `out_data`, `out_mask`, `out_valid` and `out_jump` hold their values.
- R7: A cycle with `out_valid` high and `out_stall` low consumes the packet. On the next cycle `out_valid`, `out_jump`, `out_mask` and `out_data` are all zero.
- R8: `upd_en` is high exactly when the machine is in `ST_RECV` and either a slice is being accepted or the output packet is being consumed in that cycle.
- R9: A slice offered with `in_valid` high while `in_stall` is high is not written. It changes neither `out_data` nor `out_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Slice present on the input |
| in_stall | output | 1 | Input held off; no slice is accepted |
| in_addr | input | ADDR_W | Sequence address (lane) of the slice |
| in_op | input | 2 | Slice opcode; 2'b10 is the jump condition |
| in_data | input | SLICE_W | Slice payload |
| out_valid | output | 1 | Rebuilt wide packet present |
| out_stall | input | 1 | Consumer not ready for the wide packet |
| out_data | output | SLICE_W*NUM_SLICES | Rebuilt wide packet, lane 0 in the low bits |
| out_mask | output | NUM_SLICES | Lanes written since the last packet was consumed |
| out_jump | output | 1 | Machine is in the jump state; the packet was closed by a jump slice |
| upd_en | output | 1 | Update enable: data-ready state and (slice accepted or packet consumed) |

## Verification
The assertions assume that `out_stall` and the input slice fields are stable and known at each clock edge. They also assume that upstream keeps offering slices whether or not `in_stall` is high, so the stall path is exercised rather than avoided. The bench drives every input just after a falling edge and holds it through the next rising edge, so sampling is unambiguous. Its directed sequences include in-order and out-of-order lanes, repeated lanes, jump slices at the first and last lanes, and slices offered into a stalled output. A long constrained-random run mixes all opcode values with random output stall.

// File: rtl/slice_reasm_pkg.sv
package slice_reasm_pkg;

    typedef enum logic [0:0] {
        ST_RECV = 1'b0,
        ST_JUMP = 1'b1
    } rsm_state_e;

    // Jump condition: designated high bit set, designated low bit clear.
    function automatic logic jump_cond(input logic [1:0] op);
        return op[1] & ~op[0];
    endfunction

endpackage

// File: rtl/rsm_ctrl.sv
module rsm_ctrl
    import slice_reasm_pkg::*;
#(
    parameter int NUM_SLICES = 4,
    parameter int ADDR_W     = $clog2(NUM_SLICES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [1:0]        in_op,
    input  logic              out_stall,
    output logic              in_stall,
    output logic              out_valid,
    output logic              accept,
    output logic              drain,
    output logic              upd_en,
    output logic              jump_st
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_SLICES - 1);

    rsm_state_e state_q, state_d;
    logic       vld_q;
    logic       close_pkt;

    always_comb begin
        accept    = in_valid && !vld_q;
        drain     = vld_q && !out_stall;
        close_pkt = accept && ((in_addr == LAST_ADDR) || jump_cond(in_op));
        state_d   = state_q;
        unique case (state_q)
            ST_RECV: if (accept && jump_cond(in_op)) state_d = ST_JUMP;
            ST_JUMP: if (!out_stall)                 state_d = ST_RECV;
            default:                                 state_d = ST_RECV;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RECV;
        else     state_q <= state_d;
    end

    // Completion flag / output valid
    always_ff @(posedge clk) begin
        if (rst)            vld_q <= 1'b0;
        else if (drain)     vld_q <= 1'b0;
        else if (close_pkt) vld_q <= 1'b1;
    end

    // Outputs
    always_comb begin
        in_stall  = vld_q;
        out_valid = vld_q;
        jump_st   = (state_q == ST_JUMP);
        upd_en    = (state_q == ST_RECV) && (accept || drain);
    end

    a_r4_jump_enter: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RECV && accept && jump_cond(in_op)) |=> (state_q == ST_JUMP && vld_q));

    a_r5_jump_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_JUMP && out_stall) |=> (state_q == ST_JUMP));

    a_r3_last_done: assert property (@(posedge clk) disable iff (rst)
        (accept && in_addr == LAST_ADDR && !jump_cond(in_op)) |=> (vld_q && state_q == ST_RECV));

    a_r8_no_upd_in_jump: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_JUMP) |-> !upd_en);

endmodule

// File: rtl/rsm_slot_array.sv
module rsm_slot_array #(
    parameter int SLICE_W    = 8,
    parameter int NUM_SLICES = 4,
    parameter int ADDR_W     = $clog2(NUM_SLICES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr,
    input  logic                          clr,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [SLICE_W-1:0]            data,
    output logic [SLICE_W*NUM_SLICES-1:0] wide,
    output logic [NUM_SLICES-1:0]         mask
);
    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_lane
        logic lane_sel;
        assign lane_sel = wr && (addr == ADDR_W'(i));

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                wide[i*SLICE_W +: SLICE_W] <= '0;
                mask[i]                    <= 1'b0;
            end else if (lane_sel) begin
                wide[i*SLICE_W +: SLICE_W] <= data;
                mask[i]                    <= 1'b1;
            end
        end
    end

    a_r2_lane_written: assert property (@(posedge clk) disable iff (rst)
        (wr && !clr) |=> (mask[$past(addr)] && wide[$past(addr)*SLICE_W +: SLICE_W] == $past(data)));

    a_r7_cleared: assert property (@(posedge clk) disable iff (rst)
        clr |=> (mask == '0 && wide == '0));

endmodule

// File: rtl/slice_reassembler.sv
module slice_reassembler
    import slice_reasm_pkg::*;
#(
    parameter int SLICE_W    = 8,
    parameter int NUM_SLICES = 4,
    parameter int ADDR_W     = $clog2(NUM_SLICES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    output logic                          in_stall,
    input  logic [ADDR_W-1:0]             in_addr,
    input  logic [1:0]                    in_op,
    input  logic [SLICE_W-1:0]            in_data,
    output logic                          out_valid,
    input  logic                          out_stall,
    output logic [SLICE_W*NUM_SLICES-1:0] out_data,
    output logic [NUM_SLICES-1:0]         out_mask,
    output logic                          out_jump,
    output logic                          upd_en
);
    logic accept;
    logic drain;

    rsm_ctrl #(
        .NUM_SLICES(NUM_SLICES),
        .ADDR_W    (ADDR_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_addr  (in_addr),
        .in_op    (in_op),
        .out_stall(out_stall),
        .in_stall (in_stall),
        .out_valid(out_valid),
        .accept   (accept),
        .drain    (drain),
        .upd_en   (upd_en),
        .jump_st  (out_jump)
    );

    rsm_slot_array #(
        .SLICE_W   (SLICE_W),
        .NUM_SLICES(NUM_SLICES),
        .ADDR_W    (ADDR_W)
    ) u_slots (
        .clk (clk),
        .rst (rst),
        .wr  (accept),
        .clr (drain),
        .addr(in_addr),
        .data(in_data),
        .wide(out_data),
        .mask(out_mask)
    );

    a_r6_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_stall) |=> (out_valid && $stable(out_data) && $stable(out_mask) && $stable(out_jump)));

    a_r5_jump_exit: assert property (@(posedge clk) disable iff (rst)
        (out_jump && !out_stall) |=> (!out_jump && !out_valid));

    a_r9_ignored_when_stalled: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_stall && out_stall) |=> ($stable(out_mask) && $stable(out_data)));

    a_r7_consumed: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_stall) |=> (!out_valid && out_mask == '0));

endmodule

// File: tb/slice_reassembler_tb.sv
`timescale 1ns/1ps
module slice_reassembler_tb;
    localparam int W = 8;
    localparam int N = 4;
    localparam int A = $clog2(N);

    logic           clk = 1'b0;
    logic           rst;
    logic           in_valid;
    logic           in_stall;
    logic [A-1:0]   in_addr;
    logic [1:0]     in_op;
    logic [W-1:0]   in_data;
    logic           out_valid;
    logic           out_stall;
    logic [W*N-1:0] out_data;
    logic [N-1:0]   out_mask;
    logic           out_jump;
    logic           upd_en;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    int             m_jump;
    int             m_vld;
    logic [W*N-1:0] m_data;
    logic [N-1:0]   m_mask;

    always #2 clk = ~clk;

    slice_reassembler #(.SLICE_W(W), .NUM_SLICES(N)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_stall(in_stall),
        .in_addr(in_addr), .in_op(in_op), .in_data(in_data),
        .out_valid(out_valid), .out_stall(out_stall), .out_data(out_data),
        .out_mask(out_mask), .out_jump(out_jump), .upd_en(upd_en)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp,
                       input string req, input string ph);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s): actual %0h expected %0h", req, ph, act, exp);
        end
    endtask

    task automatic check_regs(input string ph);
        chk(64'(out_valid), 64'(m_vld != 0), "R3", ph);
        chk(64'(out_jump),  64'(m_jump != 0), "R4", ph);
        chk(64'(out_mask),  64'(m_mask), "R2", ph);
        chk(64'(out_data),  64'(m_data), "R2", ph);
    endtask

    // One cycle: drive after falling edge, check combinational outputs,
    // advance the model at the rising edge, check registers at next falling edge.
    task automatic step(input logic v, input int a, input logic [1:0] op,
                        input logic [W-1:0] d, input logic os, input string ph);
        bit acc, drn, jmp;
        in_valid  = v;
        in_addr   = A'(a);
        in_op     = op;
        in_data   = d;
        out_stall = os;
        #1;
        acc = v && (m_vld == 0);
        drn = (m_vld != 0) && !os;
        jmp = (op == 2'b10);
        chk(64'(in_stall), 64'(m_vld != 0), "R6", ph);
        chk(64'(upd_en), 64'((m_jump == 0) && (acc || drn)), "R8", ph);
        @(posedge clk);
        if (drn) begin
            m_vld = 0; m_jump = 0; m_mask = '0; m_data = '0;
        end else if (acc) begin
            m_data[a*W +: W] = d;
            m_mask[a] = 1'b1;
            if (a == N-1 || jmp) m_vld = 1;
            if (jmp) m_jump = 1;
        end
        @(negedge clk);
        check_regs(ph);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 0; in_addr = '0; in_op = '0; in_data = '0; out_stall = 0;
        m_jump = 0; m_vld = 0; m_data = '0; m_mask = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check_regs("R1 reset");
        chk(64'(in_stall), 64'd0, "R1", "reset stall");

        // R2/R3: in-order packet, output stalled, then R6 hold and R7 drain
        for (int i = 0; i < N; i++) step(1, i, 2'b00, W'(8'h10 + i), 1, "R3 in-order");
        step(1, 1, 2'b01, 8'hEE, 1, "R9 offered into stall");
        step(1, 2, 2'b10, 8'hDD, 1, "R9 jump offered into stall");
        step(0, 0, 2'b00, 8'h00, 1, "R6 hold");
        step(0, 0, 2'b00, 8'h00, 0, "R7 drain");
        step(0, 0, 2'b00, 8'h00, 0, "R7 idle");

        // R2: out of order with overwrite, op 11 is not a jump
        step(1, 2, 2'b11, 8'hA2, 0, "R2 ooo");
        step(1, 0, 2'b01, 8'hA0, 0, "R2 ooo");
        step(1, 0, 2'b00, 8'hB0, 0, "R2 overwrite");
        step(1, 3, 2'b11, 8'hA3, 0, "R3 last non-jump");
        step(1, 1, 2'b00, 8'h55, 0, "R7 drain with offer");
        step(0, 0, 2'b00, 8'h00, 0, "R7 idle");

        // R4/R5: jump mid-packet, stalled, then released
        step(1, 0, 2'b00, 8'hC0, 0, "R4 pre");
        step(1, 1, 2'b10, 8'hC1, 1, "R4 jump");
        step(1, 2, 2'b00, 8'hC2, 1, "R5 hold jump");
        step(0, 0, 2'b00, 8'h00, 1, "R5 hold jump");
        step(0, 0, 2'b00, 8'h00, 0, "R5 exit");
        step(0, 0, 2'b00, 8'h00, 0, "R5 after");

        // R4: jump on first lane and on last lane
        step(1, 0, 2'b10, 8'h71, 0, "R4 jump lane0");
        step(0, 0, 2'b00, 8'h00, 0, "R5 exit");
        step(1, N-1, 2'b10, 8'h72, 0, "R4 jump last lane");
        step(0, 0, 2'b00, 8'h00, 0, "R5 exit");

        // Constrained random mix
        for (int k = 0; k < 600; k++) begin
            logic [1:0] op;
            op = 2'($urandom_range(0, 3));
            if (op == 2'b10 && $urandom_range(0, 3) != 0) op = 2'b00;
            step(1'($urandom_range(0, 1)), $urandom_range(0, N-1), op,
                 W'($urandom), 1'($urandom_range(0, 2) == 0), "R2 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule